// File: doc/BRIEF.md
# Page-Addressed Monochrome Display RAM

This block holds the pixel memory of a small monochrome graphic display controller and decodes the byte commands that address it. The array is 65 lines by 132 columns, one bit per pixel. A host reaches it through an 8-bit request stream. Each request byte is marked as a command or as data, and data requests are marked as a write or a read. A data byte covers eight vertically adjacent lines of one column: bit k of the byte is line 8*page + k. Pages 0 to 7 hold lines 0 to 63. Page 8 holds only line 64, on bit 0.

Command bytes load a page register, a column address sent as two nibbles, and a 6-bit start line. Each data access moves the column forward by one. It saturates at 131 and does not wrap into the next page. Data reads return their byte on a response stream. The host keeps request valid high until ready is seen. The block lowers request ready while a read response is waiting and response ready is low. A response, once valid, holds its byte until it is taken.

A separate scan port serves the panel refresh logic. It takes a panel row number and, one cycle later, returns the 132-bit RAM line (start + row) mod 64.

Top module: `lcd_pixel_ram`

## Requirements
- R1: A synchronous reset clears the page, column and start-line registers to 0 and drops rsp_valid and scan_valid.
- R2: A command byte 0xB0|p (upper nibble 0xB) loads the 4-bit page register with p.
- R3: A command 0x10|h loads column bits 7:4 with h, and a command 0x00|l loads column bits 3:0 with l. Each command leaves the other nibble as it was.
- R4: A command 0x40|s (bits 7:6 = 01) loads the start line with s.
- R5: Command bytes with upper nibble 0x2, 0x3, 0x8, 0x9, 0xA, 0xC, 0xD, 0xE or 0xF change nothing. So do command-marked read requests.
- R6: A data write stores bit k of the byte at line 8*page+k, current column. A data read gives the stored byte on rsp_byte with rsp_valid high in the cycle after acceptance.
- R7: After each accepted data write or read, the column rises by one if it is below 131. Otherwise it stays as it was.
- R8: On page 8, only bit 0 (line 64) is written, and reads return bits 7:1 as 0.
- R9: When page > 8 or column > 131, data writes change no pixel and data reads return 0x00.
- R10: A scan request for row r returns, one cycle later with scan_valid high, RAM line (start + r) mod 64, with column c on scan_pixels[c]. Line 64 never appears.
- R11: While rsp_valid is high and rsp_ready is low, req_ready is low and rsp_byte is held.
- R12: Reset leaves the pixel contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request byte valid |
| req_ready | output | 1 | Request can be accepted |
| req_is_data | input | 1 | 1 = data byte, 0 = command byte |
| req_read | input | 1 | 1 = read request (data only) |
| req_byte | input | 8 | Command or write data byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_byte | output | 8 | Read data |
| scan_en | input | 1 | Scan row request |
| scan_row | input | 6 | Panel row number |
| scan_valid | output | 1 | Scan result valid |
| scan_pixels | output | 132 | Pixel row, column c on bit c |

## Verification
Distinct byte patterns (0xA5, 0x3C, 0x5A, 0x66) are written and read back at nearby columns. This shows whether bit order is kept and whether each access moves the column by one. Pages 8 and 9 and column 132 are written with values different from bytes already stored where a truncated address would land, so aliasing shows up as a changed read-back. Scans with start line 0 and 63 use columns whose set bits identify line 0, line 1, line 63 and line 64, so a wrong modulo or an off-by-one row shows. Ignored commands sit between a column load and a read-back, which shows whether any of them touched the address.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  parameter int LINES    = 65;
  parameter int COLS     = 132;
  parameter int BUS_W    = 8;
  parameter int PAGE_W   = 4;
  parameter int START_W  = 6;
  localparam int LINE_AW = $clog2(LINES);
  localparam int COL_W   = $clog2(COLS);
  localparam int NIB_W   = COL_W / 2;
  localparam int MAX_PAGE = (LINES - 1) / BUS_W;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PAGE,
    OP_COL_HI,
    OP_COL_LO,
    OP_START
  } cmd_op_e;

  typedef struct packed {
    cmd_op_e            op;
    logic [START_W-1:0] arg;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [BUS_W-1:0] b);
    cmd_t c;
    c.op  = OP_NONE;
    c.arg = b[START_W-1:0];
    if (b[7:6] == 2'b01)      c.op = OP_START;
    else if (b[7:4] == 4'hB)  c.op = OP_PAGE;
    else if (b[7:4] == 4'h1)  c.op = OP_COL_HI;
    else if (b[7:4] == 4'h0)  c.op = OP_COL_LO;
    return c;
  endfunction
endpackage

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_is_data,
  input  logic             req_read,
  output logic             req_ready,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_byte,
  input  logic [BUS_W-1:0] rd_byte,
  output logic             cmd_fire,
  output logic             wr_fire,
  output logic             rd_fire
);
  logic accept;
  logic rsp_valid_q;
  logic [BUS_W-1:0] rsp_byte_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign cmd_fire  = accept && !req_is_data && !req_read;
  assign wr_fire   = accept && req_is_data && !req_read;
  assign rd_fire   = accept && req_is_data && req_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
    end else if (rd_fire) begin
      rsp_valid_q <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rsp_byte_q <= rd_byte;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_byte  = rsp_byte_q;
endmodule

// File: rtl/lcd_addr_regs.sv
module lcd_addr_regs
  import lcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_fire,
  input  logic [BUS_W-1:0]   cmd_byte,
  input  logic               data_fire,
  output logic [PAGE_W-1:0]  page_q,
  output logic [COL_W-1:0]   col_q,
  output logic [START_W-1:0] start_q,
  output logic               addr_ok
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(MAX_PAGE);

  cmd_t cmd;
  logic [COL_W-1:0] col_step;

  assign cmd      = decode_cmd(cmd_byte);
  assign col_step = (col_q < LAST_COL) ? col_q + COL_W'(1) : col_q;
  assign addr_ok  = (page_q <= LAST_PAGE) && (col_q <= LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      col_q   <= '0;
      start_q <= '0;
    end else if (cmd_fire) begin
      case (cmd.op)
        OP_PAGE:   page_q <= cmd.arg[PAGE_W-1:0];
        OP_COL_HI: col_q[COL_W-1:NIB_W] <= cmd.arg[NIB_W-1:0];
        OP_COL_LO: col_q[NIB_W-1:0] <= cmd.arg[NIB_W-1:0];
        OP_START:  start_q <= cmd.arg;
        default:   ;
      endcase
    end else if (data_fire) begin
      col_q <= col_step;
    end
  end
endmodule

// File: rtl/lcd_line_store.sv
module lcd_line_store
  import lcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               addr_ok,
  input  logic [PAGE_W-1:0]  page,
  input  logic [COL_W-1:0]   col,
  input  logic [BUS_W-1:0]   wr_byte,
  output logic [BUS_W-1:0]   rd_byte,
  input  logic [START_W-1:0] start_line,
  input  logic               scan_en,
  input  logic [START_W-1:0] scan_row,
  output logic               scan_valid,
  output logic [COLS-1:0]    scan_pixels
);
  localparam int BIT_AW = $clog2(BUS_W);
  localparam logic [LINE_AW-1:0] LAST_LINE = LINE_AW'(LINES - 1);

  logic [COLS-1:0]    lines_q [LINES];
  logic [LINE_AW-1:0] line_idx [BUS_W];
  logic [BUS_W-1:0]   line_ok;
  logic [START_W-1:0] scan_line;
  logic               scan_valid_q;
  logic [COLS-1:0]    scan_pixels_q;

  for (genvar k = 0; k < BUS_W; k++) begin : g_lane
    assign line_idx[k] = LINE_AW'({page, BIT_AW'(k)});
    assign line_ok[k]  = addr_ok && (line_idx[k] <= LAST_LINE);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < BUS_W; k++) begin
        if (line_ok[k]) lines_q[line_idx[k]][col] <= wr_byte[k];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < BUS_W; k++) begin
      if (line_ok[k]) rd_byte[k] = lines_q[line_idx[k]][col];
    end
  end

  assign scan_line = start_line + scan_row;

  always_ff @(posedge clk) begin
    if (rst) scan_valid_q <= 1'b0;
    else     scan_valid_q <= scan_en;
  end

  always_ff @(posedge clk) begin
    if (scan_en) scan_pixels_q <= lines_q[LINE_AW'(scan_line)];
  end

  assign scan_valid  = scan_valid_q;
  assign scan_pixels = scan_pixels_q;
endmodule

// File: rtl/lcd_pixel_ram.sv
module lcd_pixel_ram
  import lcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_data,
  input  logic               req_read,
  input  logic [BUS_W-1:0]   req_byte,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BUS_W-1:0]   rsp_byte,
  input  logic               scan_en,
  input  logic [START_W-1:0] scan_row,
  output logic               scan_valid,
  output logic [COLS-1:0]    scan_pixels
);
  logic               cmd_fire, wr_fire, rd_fire, addr_ok;
  logic [PAGE_W-1:0]  page_w;
  logic [COL_W-1:0]   col_w;
  logic [START_W-1:0] start_w;
  logic [BUS_W-1:0]   rd_byte_w;

  lcd_host_port u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_is_data(req_is_data), .req_read(req_read),
    .req_ready(req_ready), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .rd_byte(rd_byte_w),
    .cmd_fire(cmd_fire), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  lcd_addr_regs u_regs (
    .clk(clk), .rst(rst),
    .cmd_fire(cmd_fire), .cmd_byte(req_byte),
    .data_fire(wr_fire || rd_fire),
    .page_q(page_w), .col_q(col_w), .start_q(start_w), .addr_ok(addr_ok)
  );

  lcd_line_store u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_fire), .addr_ok(addr_ok),
    .page(page_w), .col(col_w), .wr_byte(req_byte), .rd_byte(rd_byte_w),
    .start_line(start_w), .scan_en(scan_en), .scan_row(scan_row),
    .scan_valid(scan_valid), .scan_pixels(scan_pixels)
  );
endmodule

// File: rtl/lcd_pixel_ram_chk.sv
module lcd_pixel_ram_chk
  import lcd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_data,
  input logic              req_read,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BUS_W-1:0]  rsp_byte,
  input logic              scan_en,
  input logic              scan_valid,
  input logic [PAGE_W-1:0] page_q,
  input logic [COL_W-1:0]  col_q
);
  logic data_acc, rd_acc;
  assign data_acc = req_valid && req_ready && req_is_data;
  assign rd_acc   = data_acc && req_read;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !scan_valid && page_q == '0 && col_q == '0));

  a_r6_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rsp_valid);

  a_r7_col_step: assert property (@(posedge clk) disable iff (rst)
    (data_acc && col_q < COL_W'(COLS - 1)) |=> (col_q == $past(col_q) + COL_W'(1)));

  a_r7_col_hold: assert property (@(posedge clk) disable iff (rst)
    (data_acc && col_q >= COL_W'(COLS - 1)) |=> $stable(col_q));

  a_r8_page8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && page_q == PAGE_W'(MAX_PAGE)) |=> (rsp_byte[BUS_W-1:1] == '0));

  a_r9_out_of_range_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && (page_q > PAGE_W'(MAX_PAGE) || col_q > COL_W'(COLS - 1)))
      |=> (rsp_byte == '0));

  a_r10_scan_latency: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> scan_valid);

  a_r10_scan_idle: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> !scan_valid);

  a_r11_stall_ready: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));
endmodule

bind lcd_pixel_ram lcd_pixel_ram_chk u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_is_data(req_is_data), .req_read(req_read),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
  .scan_en(scan_en), .scan_valid(scan_valid),
  .page_q(page_w), .col_q(col_w)
);

// File: tb/lcd_pixel_ram_test.sv
module lcd_pixel_ram_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_is_data = 1'b0, req_read = 1'b0;
  logic [7:0]   req_byte = 8'h00;
  logic         rsp_ready = 1'b1;
  logic         scan_en = 1'b0;
  logic [5:0]   scan_row = 6'd0;
  logic         req_ready, rsp_valid, scan_valid;
  logic [7:0]   rsp_byte;
  logic [131:0] scan_pixels;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lcd_pixel_ram uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_read(req_read), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .scan_en(scan_en), .scan_row(scan_row),
    .scan_valid(scan_valid), .scan_pixels(scan_pixels)
  );

  localparam logic [1:0] K_CMD = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
  // entry = {kind, byte, expected read byte, requirement number}
  localparam int NV = 48;
  localparam logic [21:0] VEC [NV] = '{
    // R2 R3 R6 R7: write two bytes at column 5, read both back
    {K_CMD, 8'hB0, 8'h00, 4'd2}, {K_CMD, 8'h10, 8'h00, 4'd3},
    {K_CMD, 8'h05, 8'h00, 4'd3}, {K_WR,  8'hA5, 8'h00, 4'd6},
    {K_WR,  8'h3C, 8'h00, 4'd6}, {K_CMD, 8'h05, 8'h00, 4'd3},
    {K_RD,  8'hA5, 8'hA5, 4'd6}, {K_RD,  8'h3C, 8'h3C, 4'd7},
    // R5: ignored commands between a column load and a read
    {K_CMD, 8'h05, 8'h00, 4'd3}, {K_CMD, 8'h2F, 8'h00, 4'd5},
    {K_CMD, 8'h81, 8'h00, 4'd5}, {K_CMD, 8'hA7, 8'h00, 4'd5},
    {K_CMD, 8'hF3, 8'h00, 4'd5}, {K_RD,  8'h00, 8'hA5, 4'd5},
    // R7: saturation at column 131 on page 3
    {K_CMD, 8'hB3, 8'h00, 4'd2}, {K_CMD, 8'h18, 8'h00, 4'd3},
    {K_CMD, 8'h03, 8'h00, 4'd3}, {K_WR,  8'hFF, 8'h00, 4'd7},
    {K_WR,  8'h11, 8'h00, 4'd7}, {K_CMD, 8'h03, 8'h00, 4'd3},
    {K_RD,  8'h00, 8'h11, 4'd7}, {K_RD,  8'h00, 8'h11, 4'd7},
    // R8: page 8 keeps bit 0 only
    {K_CMD, 8'hB8, 8'h00, 4'd2}, {K_CMD, 8'h10, 8'h00, 4'd3},
    {K_CMD, 8'h00, 8'h00, 4'd3}, {K_WR,  8'hFF, 8'h00, 4'd8},
    {K_CMD, 8'h00, 8'h00, 4'd3}, {K_RD,  8'h00, 8'h01, 4'd8},
    // R9: page 9 must not alias page 1
    {K_CMD, 8'hB1, 8'h00, 4'd2}, {K_CMD, 8'h00, 8'h00, 4'd3},
    {K_WR,  8'h5A, 8'h00, 4'd6}, {K_CMD, 8'hB9, 8'h00, 4'd2},
    {K_CMD, 8'h00, 8'h00, 4'd3}, {K_WR,  8'hFF, 8'h00, 4'd9},
    {K_RD,  8'h00, 8'h00, 4'd9}, {K_CMD, 8'hB1, 8'h00, 4'd2},
    {K_CMD, 8'h00, 8'h00, 4'd3}, {K_RD,  8'h00, 8'h5A, 4'd9},
    // R9: column 132 must not alias column 4
    {K_CMD, 8'hB0, 8'h00, 4'd2}, {K_CMD, 8'h04, 8'h00, 4'd3},
    {K_WR,  8'h66, 8'h00, 4'd6}, {K_CMD, 8'h18, 8'h00, 4'd3},
    {K_CMD, 8'h04, 8'h00, 4'd3}, {K_WR,  8'h77, 8'h00, 4'd9},
    {K_RD,  8'h00, 8'h00, 4'd9}, {K_CMD, 8'h10, 8'h00, 4'd3},
    {K_CMD, 8'h04, 8'h00, 4'd3}, {K_RD,  8'h00, 8'h66, 4'd9}
  };

  task automatic check(input bit ok, input string req, input logic [131:0] act,
                       input logic [131:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Ends on the negedge after acceptance; a read result is visible then.
  task automatic xfer(input bit is_data, input bit rd, input logic [7:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_is_data = is_data; req_read = rd; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_read = 1'b0;
  endtask

  task automatic scan(input logic [5:0] row);
    @(negedge clk);
    scan_en = 1'b1; scan_row = row;
    @(negedge clk);
    scan_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state at the ports
    check(!rsp_valid && !scan_valid && req_ready, "R1 idle after reset",
          {rsp_valid, scan_valid, req_ready}, 3'b001);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][21:20] != K_CMD, VEC[i][21:20] == K_RD, VEC[i][19:12]);
      if (VEC[i][21:20] == K_RD)
        check(rsp_valid && rsp_byte == VEC[i][11:4],
              $sformatf("R%0d table[%0d]", VEC[i][3:0], i), rsp_byte, VEC[i][11:4]);
    end

    // R10: known bits on lines 0, 1 and 63
    xfer(0, 0, 8'hB0); xfer(0, 0, 8'h10); xfer(0, 0, 8'h00);
    xfer(1, 0, 8'h02); xfer(1, 0, 8'h01);
    xfer(0, 0, 8'hB7); xfer(0, 0, 8'h00); xfer(1, 0, 8'h80);
    xfer(0, 0, 8'h40);
    scan(6'd0);
    check(scan_valid && scan_pixels[1:0] == 2'b10, "R10 start0 row0 line0",
          scan_pixels[1:0], 2'b10);
    scan(6'd1);
    check(scan_pixels[1:0] == 2'b01, "R10 start0 row1 line1", scan_pixels[1:0], 2'b01);
    xfer(0, 0, 8'h7F); // R4 start line 63
    scan(6'd0);
    check(scan_pixels[0] == 1'b1, "R4 start63 row0 line63", scan_pixels[0], 1'b1);
    scan(6'd1);
    check(scan_pixels[1:0] == 2'b10, "R10 wrap row1 to line0 not 64",
          scan_pixels[1:0], 2'b10);
    scan(6'd2);
    check(scan_pixels[1:0] == 2'b01, "R10 row2 line1", scan_pixels[1:0], 2'b01);
    xfer(0, 0, 8'hE5); // R5 ignored, start stays 63
    scan(6'd1);
    check(scan_pixels[1:0] == 2'b10, "R5 start kept", scan_pixels[1:0], 2'b10);
    xfer(0, 1, 8'h40); // R5 command read is ignored
    check(!rsp_valid, "R5 command read gives no response", rsp_valid, 1'b0);
    scan(6'd1);
    check(scan_pixels[1:0] == 2'b10, "R5 command read kept start", scan_pixels[1:0], 2'b10);

    // R11: stalled response
    xfer(0, 0, 8'hB0); xfer(0, 0, 8'h05);
    rsp_ready = 1'b0;
    xfer(1, 1, 8'h00);
    held = rsp_byte;
    check(rsp_valid && rsp_byte == 8'hA5, "R11 response data", rsp_byte, 8'hA5);
    check(!req_ready, "R11 ready low while stalled", req_ready, 1'b0);
    req_valid = 1'b1; req_is_data = 1'b1; req_read = 1'b0; req_byte = 8'hEE;
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_byte == held, "R11 response held", rsp_byte, held);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid, "R11 response taken", rsp_valid, 1'b0);
    xfer(1, 1, 8'h00); // column 6 not overwritten by the stalled write
    check(rsp_byte == 8'h3C, "R11 stalled write dropped", rsp_byte, 8'h3C);

    // R12 and R1: reset keeps pixels, address returns to page 0 column 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xfer(1, 1, 8'h00);
    check(rsp_byte == 8'h02, "R12 pixels kept, R1 address zero", rsp_byte, 8'h02);
    scan(6'd1);
    check(scan_pixels[1:0] == 2'b01, "R1 start line zero", scan_pixels[1:0], 2'b01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule